// File: doc/BRIEF.md
# Unique ID CRC-8 Serializer

This block keeps a 64-bit device identifier and moves it across a one-bit serial link. The identifier has three fields. The low 8 bits are a family code, which comes out of reset as 55h. The next 48 bits are a serial number. The top 8 bits are a CRC-8 taken over the 56 bits below it. The family code and serial number are written through a parallel load port. The CRC is never stored: a bit-serial shift register with XOR feedback recomputes it on every transfer.

A one-cycle start strobe opens a 64-cycle transfer. The mode input, sampled with the strobe, selects one of two modes:

- **Generate mode.** The block sends the 56 stored bits and then the 8 CRC bits it has just computed.
- **Check mode.** The block takes 64 bits from a remote sender on its serial input. It runs them through the same register and reports whether the remainder is zero.

In both modes a one-cycle done flag closes the transfer, and a result flag reports whether the CRC is consistent.

Top module: `uid_crc_serializer`

## Requirements
- R1: After reset, bit_valid_o, done_o and crc_ok_o are 0. The stored identifier holds family code 55h and serial number 0.
- R2: A pulse on load_i while no transfer is active replaces the stored family code and serial number. A pulse on load_i during a transfer leaves the stored identifier unchanged.
- R3: A start_i pulse while idle raises bit_valid_o on the next cycle and holds it for exactly 64 consecutive cycles. In generate mode (mode_i = 0), output bits 0 to 55 are the family code and then the serial number, each sent least significant bit first.
- R4: In generate mode, output bits 56 to 63 are the CRC of the first 56 bits, sent least significant bit first. The CRC uses polynomial x^8+x^5+x^4+1 in shift-right form (feedback constant 8Ch) with the register starting at 00h. For family 02h and serial bytes 1Ch, B8h, 01h, 00h, 00h, 00h, the CRC is A2h.
- R5: In check mode (mode_i = 1), bit_i is sampled at each rising clock edge that ends a cycle with bit_valid_o high. crc_ok_o is 1 after the transfer only if the register is zero after all 64 sampled bits. Any single flipped bit therefore gives 0.
- R6: In check mode, bit_o stays 0 for the whole transfer.
- R7: done_o is high for exactly one cycle: the cycle after the last bit_valid_o cycle. crc_ok_o changes only in that same cycle and is cleared in the cycle after the next accepted start.
- R8: A start_i pulse during an active transfer is ignored. The transfer is neither restarted nor lengthened.
- R9: At the end of a generate-mode transfer, crc_ok_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Write family code and serial number into the identifier store |
| family_i | input | 8 | Family code to load |
| serial_i | input | 48 | Serial number to load |
| start_i | input | 1 | Begin a 64-bit transfer |
| mode_i | input | 1 | Transfer mode: 0 generate, 1 check |
| bit_i | input | 1 | Received serial bit in check mode |
| bit_o | output | 1 | Serial bit sent in generate mode |
| bit_valid_o | output | 1 | High during each of the 64 bit cycles |
| done_o | output | 1 | One-cycle pulse after the last bit |
| crc_ok_o | output | 1 | Remainder was zero at the end of the last transfer |

## Verification
The bench uses the default build: 8-bit family, 48-bit serial, 8-bit CRC with feedback constant 8Ch, and reset family 55h.

The small family field allows every family code from 0 to 255 to be swept. Each code is paired with a derived serial number and exercised three times:
- a generate transfer;
- a check transfer fed the correct 64 bits;
- a check transfer with one bit flipped, its position moving through all 64 places.

Expected CRCs come from a byte-wise arithmetic model in the bench and are anchored by one published-style known vector. Further runs push start and load pulses into the middle of a transfer.

// File: rtl/uid_pkg.sv
package uid_pkg;
  typedef enum logic {
    UID_GEN = 1'b0,
    UID_CHK = 1'b1
  } uid_mode_e;

  localparam int unsigned UID_FAM_W = 8;
  localparam int unsigned UID_SER_W = 48;
  localparam int unsigned UID_CRC_W = 8;
endpackage

// File: rtl/uid_crc_lfsr.sv
module uid_crc_lfsr #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  POLY = 8'h8C,
  parameter logic [W-1:0]  INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc_d
);
  logic [W-1:0] crc_q;
  logic         fb;

  // shift-right form: feedback is the outgoing LSB mixed with the new bit
  assign fb = crc_q[0] ^ din;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign crc_d[i] = POLY[i] & fb;
    end else begin : g_mid
      assign crc_d[i] = crc_q[i+1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= INIT;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end
endmodule

// File: rtl/uid_id_store.sv
module uid_id_store #(
  parameter int unsigned        FAM_W   = 8,
  parameter int unsigned        SER_W   = 48,
  parameter logic [FAM_W-1:0]   FAM_RST = 8'h55
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     busy,
  input  logic [FAM_W-1:0]         fam_i,
  input  logic [SER_W-1:0]         ser_i,
  output logic [FAM_W+SER_W-1:0]   id_q
);
  logic [FAM_W-1:0] fam_q;
  logic [SER_W-1:0] ser_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fam_q <= FAM_RST;
      ser_q <= '0;
    end else if (load && !busy) begin
      fam_q <= fam_i;
      ser_q <= ser_i;
    end
  end

  assign id_q = {ser_q, fam_q};

  AST_LOAD_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (load && busy) |=> $stable(id_q)); // R2
  AST_LOAD_TAKEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (id_q == $past({ser_i, fam_i}))); // R2
endmodule

// File: rtl/uid_data_shifter.sv
module uid_data_shifter #(
  parameter int unsigned W = 56
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         head_o,
  output logic         nxt_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= din;
    end else if (shift) begin
      sh_q <= {1'b0, sh_q[W-1:1]};
    end
  end

  assign head_o = sh_q[0];
  assign nxt_o  = sh_q[1];
endmodule

// File: rtl/uid_bit_seq.sv
module uid_bit_seq #(
  parameter int unsigned N  = 64,
  parameter int unsigned CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          launch_o,
  output logic          active_q,
  output logic          last_o,
  output logic [CW-1:0] cnt_q,
  output logic          done_q
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  assign launch_o = start && !active_q;
  assign last_o   = active_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_o) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q != LAST) |=> (active_q && cnt_q == CW'($past(cnt_q) + 1'b1))); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (done_q && !active_q)); // R7
endmodule

// File: rtl/uid_crc_serializer.sv
module uid_crc_serializer
  import uid_pkg::*;
#(
  parameter int unsigned              FAM_W    = UID_FAM_W,
  parameter int unsigned              SER_W    = UID_SER_W,
  parameter int unsigned              CRC_W    = UID_CRC_W,
  parameter logic [CRC_W-1:0]         CRC_POLY = 8'h8C,
  parameter logic [CRC_W-1:0]         CRC_INIT = '0,
  parameter logic [FAM_W-1:0]         FAM_RST  = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [FAM_W-1:0]  family_i,
  input  logic [SER_W-1:0]  serial_i,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              bit_i,
  output logic              bit_o,
  output logic              bit_valid_o,
  output logic              done_o,
  output logic              crc_ok_o
);
  localparam int unsigned DATA_N  = FAM_W + SER_W;
  localparam int unsigned TOTAL_N = DATA_N + CRC_W;
  localparam int unsigned CW      = $clog2(TOTAL_N);

  logic [DATA_N-1:0] id_q;
  logic              launch, active, last_bit, done_q;
  logic [CW-1:0]     cnt;
  logic [CW:0]       next_idx;
  logic [CRC_W-1:0]  crc_d;
  logic              sh_head, sh_nxt;
  logic              in_bit;
  logic              bit_q, ok_q;
  uid_mode_e         mode_q;

  uid_id_store #(.FAM_W(FAM_W), .SER_W(SER_W), .FAM_RST(FAM_RST)) store_i (
    .clk(clk), .rst(rst), .load(load_i), .busy(active),
    .fam_i(family_i), .ser_i(serial_i), .id_q(id_q)
  );

  uid_bit_seq #(.N(TOTAL_N), .CW(CW)) seq_i (
    .clk(clk), .rst(rst), .start(start_i), .launch_o(launch),
    .active_q(active), .last_o(last_bit), .cnt_q(cnt), .done_q(done_q)
  );

  uid_data_shifter #(.W(DATA_N)) shf_i (
    .clk(clk), .rst(rst), .load(launch), .shift(active),
    .din(id_q), .head_o(sh_head), .nxt_o(sh_nxt)
  );

  // the register absorbs whatever travels on the wire in this cycle
  assign in_bit = (mode_q == UID_CHK) ? bit_i : bit_q;

  uid_crc_lfsr #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk(clk), .rst(rst), .clr(launch), .en(active), .din(in_bit), .crc_d(crc_d)
  );

  assign next_idx = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= UID_GEN;
      bit_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else if (launch) begin
      mode_q <= uid_mode_e'(mode_i);
      ok_q   <= 1'b0;
      bit_q  <= (uid_mode_e'(mode_i) == UID_CHK) ? 1'b0 : id_q[0];
    end else if (active) begin
      if (last_bit) begin
        bit_q <= 1'b0;
        ok_q  <= (crc_d == '0);
      end else if (mode_q == UID_CHK) begin
        bit_q <= 1'b0;
      end else if (next_idx < (CW+1)'(DATA_N)) begin
        bit_q <= sh_nxt;
      end else begin
        bit_q <= crc_d[0];
      end
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = active;
  assign done_o      = done_q;
  assign crc_ok_o    = ok_q;

  AST_CHK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (active && mode_q == UID_CHK) |-> !bit_o); // R6
  AST_GEN_CLEAN_END: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == UID_GEN) |-> crc_ok_o); // R9
  AST_VALID_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_valid_o) |-> $past(start_i)); // R3
  AST_GEN_BIT_TRACK: assert property (@(posedge clk) disable iff (rst)
    (active && mode_q == UID_GEN && cnt < CW'(DATA_N)) |-> (bit_o == sh_head)); // R3
  AST_OK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!launch && !last_bit) |=> $stable(crc_ok_o)); // R7
endmodule

// File: tb/uid_crc_serializer_tb.sv
module uid_crc_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [7:0]  family_i = '0;
  logic [47:0] serial_i = '0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_o, bit_valid_o, done_o, crc_ok_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uid_crc_serializer dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .family_i(family_i),
    .serial_i(serial_i), .start_i(start_i), .mode_i(mode_i), .bit_i(bit_i),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .done_o(done_o), .crc_ok_o(crc_ok_o)
  );

  task automatic check(input bit good, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte-wise reflected CRC-8, polynomial x^8+x^5+x^4+1, init 00h
  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < 7; b++) begin
      logic [7:0] byt = d[b*8 +: 8];
      for (int i = 0; i < 8; i++) begin
        logic mix = c[0] ^ byt[0];
        c   = c >> 1;
        if (mix) c = c ^ 8'h8C;
        byt = byt >> 1;
      end
    end
    return c;
  endfunction

  task automatic do_load(input logic [7:0] f, input logic [47:0] s);
    @(negedge clk);
    load_i = 1'b1; family_i = f; serial_i = s;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // one transfer; glitch indices inject start/load pulses mid-run
  task automatic run(input logic mode, input logic [63:0] drive,
                     input int start_at, input int load_at,
                     output logic [63:0] got, output int vcnt, output int dcnt,
                     output int dpos, output logic ok_end, output logic ok_first,
                     output int hi_bits);
    @(negedge clk);
    start_i = 1'b1; mode_i = mode;
    @(negedge clk);
    start_i = 1'b0;
    got = '0; vcnt = 0; dcnt = 0; dpos = -1; ok_end = 1'b0; hi_bits = 0;
    ok_first = crc_ok_o;
    for (int k = 0; k < 70; k++) begin
      if (bit_valid_o) begin
        if (vcnt < 64) got[vcnt] = bit_o;
        if (bit_o) hi_bits++;
        vcnt++;
      end
      if (done_o) begin
        dcnt++; dpos = k; ok_end = crc_ok_o;
      end
      bit_i   = (k < 64) ? drive[k] : 1'b0;
      start_i = (k == start_at);
      load_i  = (k == load_at);
      if (k == load_at) begin
        family_i = 8'hEE; serial_i = 48'hDEAD_BEEF_0123;
      end
      @(negedge clk);
    end
    load_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic gen_and_check(input logic [7:0] f, input logic [47:0] s,
                               input int start_at, input int load_at, input string tag);
    logic [63:0] got, exp;
    int vc, dc, dp, hb;
    logic oke, okf;
    exp = {ref_crc({s, f}), s, f};
    run(1'b0, 64'd0, start_at, load_at, got, vc, dc, dp, oke, okf, hb);
    check(got[55:0] == exp[55:0], {tag, " R3 data bits"}, got[55:0], exp[55:0]);
    check(got[63:56] == exp[63:56], {tag, " R4 crc bits"}, got[63:56], exp[63:56]);
    check(vc == 64, {tag, " R3/R8 valid length"}, vc, 64);
    check(dc == 1 && dp == 64, {tag, " R7 done pulse"}, dp, 64);
    check(oke == 1'b1, {tag, " R9 gen ok"}, oke, 1);
    check(okf == 1'b0, {tag, " R7 ok cleared at start"}, okf, 0);
    check(crc_ok_o == 1'b1, {tag, " R7 ok held"}, crc_ok_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, good;
    int vc, dc, dp, hb;
    logic oke, okf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(bit_valid_o == 0 && done_o == 0 && crc_ok_o == 0, "R1 reset outputs",
          {bit_valid_o, done_o, crc_ok_o}, 0);
    // R1 reset identifier: family 55h, serial 0
    gen_and_check(8'h55, 48'h0, -1, -1, "reset id");
    // R4 known vector
    do_load(8'h02, 48'h0000_0001_B81C);
    check(ref_crc({48'h0000_0001_B81C, 8'h02}) == 8'hA2, "R4 model vector",
          ref_crc({48'h0000_0001_B81C, 8'h02}), 8'hA2);
    run(1'b0, 64'd0, -1, -1, got, vc, dc, dp, oke, okf, hb);
    check(got[63:56] == 8'hA2, "R4 known crc A2", got[63:56], 8'hA2);
    // R8 start and R2 load during transfer ignored
    gen_and_check(8'h02, 48'h0000_0001_B81C, 20, 30, "glitch");
    gen_and_check(8'h02, 48'h0000_0001_B81C, -1, -1, "after glitch R2");
    // sweep all family codes
    for (int f = 0; f < 256; f++) begin
      logic [7:0]  fc = f[7:0];
      logic [47:0] sn = {fc ^ 8'h3C, ~fc, 8'hC3, fc, fc ^ 8'hA5, 8'h5A ^ {fc[3:0], fc[7:4]}};
      do_load(fc, sn);
      gen_and_check(fc, sn, -1, -1, "sweep");
      good = {ref_crc({sn, fc}), sn, fc};
      run(1'b1, good, -1, -1, got, vc, dc, dp, oke, okf, hb);
      check(oke == 1'b1 && dc == 1 && dp == 64, "R5 check clean", {dp[7:0], oke}, {8'd64, 1'b1});
      check(hb == 0, "R6 bit_o quiet in check", hb, 0);
      run(1'b1, good ^ (64'd1 << (f % 64)), -1, -1, got, vc, dc, dp, oke, okf, hb);
      check(oke == 1'b0 && vc == 64, "R5 check flipped bit", oke, 0);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule